// File: doc/BRIEF.md
# Ping-Pong Zero-Stuffing Frame Buffer

This block sits in front of a fixed 2048-point streaming FFT so that the one transform can compute a smaller one of length N (128, 256, 512, 1024 or 2048). Complex samples come in with any valid pattern. They may arrive back to back with padding after them, evenly spaced, or scattered. The block counts the valid samples into one half of a two-half RAM. When N of them have arrived, it hands that half to the read side and begins filling the other half.

The read side plays a full half out as one 2048-cycle frame with the valid output held high. Each stored sample sits at a position that is a multiple of S = 2048/N, and every other position carries zero. This is the upsampled frame that a large transform needs in order to produce a replicated spectrum of the small one.

The requested length is a 3-bit code. It is captured when a frame starts and is stored alongside the half that holds that frame. It then reappears on the output for exactly that frame.

The write side has two states. W_IDLE waits for a start; a valid sample with the start flag goes to W_FILL, or straight back to W_IDLE if the frame is already complete. W_FILL stores valid samples. On the N-th sample it goes to W_IDLE and swaps halves. A new start while filling stays in W_FILL at index 0.

The read side also has two states. R_IDLE goes to R_RUN when the current half is full. R_RUN steps through 2048 positions. At the last position it releases the half, swaps, and either stays in R_RUN (the other half is already full) or goes back to R_IDLE.

Top module: `zstuff_pingpong`

## Requirements
- R1: After reset, out_valid, out_sof, out_re, out_im and out_len are all zero.
- R2: A frame opens on a cycle with in_valid and in_sof both high; that sample takes index 0, and the index advances only on cycles with in_valid high. Valid samples that arrive while no frame is open produce no output.
- R3: When the reader is idle, out_sof is high in the third cycle after the clock edge that accepts the N-th valid sample of a frame. The edge that accepts the sample is edge k, and out_sof is visible after edge k+3.
- R4: An output frame is 2048 consecutive cycles with out_valid high. out_sof is high on its first cycle only, and out_valid never rises without out_sof.
- R5: At output position p (0 is the out_sof cycle), with S = 2048/N: if p is a multiple of S, out_re/out_im carry stored sample p/S in arrival order; otherwise both are zero.
- R6: The in_len code maps 0→128, 1→256, 2→512, 3→1024, 4→2048; codes 5, 6 and 7 behave as code 4. out_len reports the effective code.
- R7: out_len equals the effective code captured at that frame's start and is constant for the whole frame, whatever code the frame being written at the same time carries.
- R8: The two halves alternate, and frames leave in the order they completed. If the next frame is complete before the current output frame ends, its out_sof follows directly, exactly 2048 cycles after the previous out_sof.
- R9: in_valid with in_sof while a frame is open discards the partial frame and restarts storing at index 0.
- R10: After the N-th sample, further valid samples without in_sof are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | First sample of an input frame (qualified by in_valid) |
| in_len | input | 3 | Requested length code |
| in_re | input | 16 | Input real part, signed Q1.14 |
| in_im | input | 16 | Input imaginary part, signed Q1.14 |
| out_valid | output | 1 | High throughout each 2048-cycle output frame |
| out_sof | output | 1 | First cycle of an output frame |
| out_len | output | 3 | Effective length code of the frame on the output |
| out_re | output | 16 | Output real part (zero in stuffed positions) |
| out_im | output | 16 | Output imaginary part (zero in stuffed positions) |

## Verification
A wrong write index or a wrong half swap shows up in the next output frame as samples that are shifted, repeated or taken from the previous frame. The bench compares every one of the 2048 positions, so such an error is seen within that frame. A wrong read-side position or shift puts nonzero data in stuffed slots, or zero in data slots, from the first sample spacing onward. A stale length code is visible on out_len from the out_sof cycle. Errors in the hand-off between halves are seen at the very next frame boundary. They show as a latency other than three edges, a gap or overlap between back-to-back frames, or a frame that appears when none was completed.

// File: rtl/zs_pkg.sv
package zs_pkg;
    typedef enum logic {W_IDLE, W_FILL} wr_state_t;
    typedef enum logic {R_IDLE, R_RUN} rd_state_t;
endpackage

// File: rtl/zs_bank_ram.sv
module zs_bank_ram #(
    parameter int W  = 32,
    parameter int AW = 12,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/zs_wr_ctrl.sv
module zs_wr_ctrl
    import zs_pkg::*;
#(
    parameter int MAX_LOG2 = 11,
    parameter int NUM_LENS = 5,
    localparam int CW = $clog2(NUM_LENS),
    localparam int IW = MAX_LOG2,
    localparam int MIN_LOG2 = MAX_LOG2 - NUM_LENS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [CW-1:0] in_len,
    output logic          wr_en,
    output logic [IW:0]   wr_addr,
    output logic          done,
    output logic          done_bank,
    output logic [CW-1:0] done_len
);
    wr_state_t     state_q, state_d;
    logic          bank_q, bank_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [CW-1:0] len_q, len_d;
    logic          start, cur_last;
    logic [IW-1:0] cur_idx;
    logic [CW-1:0] cur_code;

    function automatic logic [CW-1:0] clamp_code(input logic [CW-1:0] c);
        return (int'(c) > NUM_LENS - 1) ? CW'(NUM_LENS - 1) : c;
    endfunction

    function automatic logic [IW-1:0] last_index(input logic [CW-1:0] c);
        logic [IW:0] n;
        n = (IW+1)'(1) << (MIN_LOG2 + int'(c));
        return n[IW-1:0] - 1'b1;
    endfunction

    always_comb begin
        start    = in_valid && in_sof;
        cur_idx  = start ? '0 : idx_q;
        cur_code = start ? clamp_code(in_len) : len_q;
        cur_last = (cur_idx == last_index(cur_code));
        unique case (state_q)
            W_IDLE: wr_en = start;
            W_FILL: wr_en = in_valid;
        endcase
    end

    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        idx_d   = idx_q;
        len_d   = len_q;
        if (wr_en) begin
            len_d = cur_code;
            if (cur_last) begin
                state_d = W_IDLE;
                bank_d  = ~bank_q;
                idx_d   = '0;
            end else begin
                state_d = W_FILL;
                idx_d   = cur_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            bank_q  <= 1'b0;
            idx_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
        end
    end

    assign wr_addr   = {bank_q, cur_idx};
    assign done      = wr_en && cur_last;
    assign done_bank = bank_q;
    assign done_len  = cur_code;

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_FILL && !in_valid) |=> $stable(idx_q));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (idx_q == IW'(1) || state_q == W_IDLE));
endmodule

// File: rtl/zs_rd_ctrl.sv
module zs_rd_ctrl
    import zs_pkg::*;
#(
    parameter int MAX_LOG2 = 11,
    parameter int NUM_LENS = 5,
    localparam int CW = $clog2(NUM_LENS),
    localparam int IW = MAX_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          done_bank,
    input  logic [CW-1:0] done_len,
    output logic [IW:0]   rd_addr,
    output logic          s_act,
    output logic          s_first,
    output logic          s_data,
    output logic [CW-1:0] s_len
);
    rd_state_t     state_q, state_d;
    logic          bank_q, bank_d;
    logic [IW-1:0] pos_q, pos_d;
    logic [1:0]    full_q, full_d;
    logic [CW-1:0] len_q [2];
    logic [CW-1:0] cur_code;
    logic [IW-1:0] mask;
    logic          run, last_pos, release_half;
    int            sh;

    always_comb begin
        cur_code = len_q[bank_q];
        sh       = (NUM_LENS - 1) - int'(cur_code);
        mask     = IW'((32'd1 << sh) - 32'd1);
        run      = (state_q == R_RUN);
        last_pos = (pos_q == '1);
        rd_addr  = {bank_q, pos_q >> sh};
    end

    always_comb begin
        state_d      = state_q;
        bank_d       = bank_q;
        pos_d        = pos_q;
        release_half = 1'b0;
        unique case (state_q)
            R_IDLE: begin
                if (full_q[bank_q]) begin
                    state_d = R_RUN;
                    pos_d   = '0;
                end
            end
            R_RUN: begin
                pos_d = pos_q + 1'b1;
                if (last_pos) begin
                    release_half = 1'b1;
                    bank_d       = ~bank_q;
                    state_d      = full_q[~bank_q] ? R_RUN : R_IDLE;
                end
            end
        endcase
        full_d = full_q;
        if (release_half) full_d[bank_q] = 1'b0;
        if (done) full_d[done_bank] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            bank_q  <= 1'b0;
            pos_q   <= '0;
            full_q  <= '0;
            len_q   <= '{default: '0};
            s_act   <= 1'b0;
            s_first <= 1'b0;
            s_data  <= 1'b0;
            s_len   <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            pos_q   <= pos_d;
            full_q  <= full_d;
            if (done) len_q[done_bank] <= done_len;
            s_act   <= run;
            s_first <= run && (pos_q == '0);
            s_data  <= run && ((pos_q & mask) == '0);
            if (run) s_len <= cur_code;
        end
    end

    // R8
    run_half_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_RUN) |-> full_q[bank_q]);

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_RUN && pos_q != '1) |=>
            (state_q == R_RUN && pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/zstuff_pingpong.sv
module zstuff_pingpong #(
    parameter int DW       = 16,
    parameter int MAX_LOG2 = 11,
    parameter int NUM_LENS = 5,
    localparam int CW = $clog2(NUM_LENS),
    localparam int AW = MAX_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [CW-1:0] in_len,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    output logic          out_sof,
    output logic [CW-1:0] out_len,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im
);
    logic            wr_en, done, done_bank;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic [CW-1:0]   done_len, s_len;
    logic            s_act, s_first, s_data;
    logic [2*DW-1:0] rdata;

    zs_wr_ctrl #(.MAX_LOG2(MAX_LOG2), .NUM_LENS(NUM_LENS)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_len(in_len), .wr_en(wr_en), .wr_addr(wr_addr), .done(done),
        .done_bank(done_bank), .done_len(done_len)
    );

    zs_bank_ram #(.W(2*DW), .AW(AW)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({in_re, in_im}),
        .raddr(rd_addr), .rdata(rdata)
    );

    zs_rd_ctrl #(.MAX_LOG2(MAX_LOG2), .NUM_LENS(NUM_LENS)) u_rd (
        .clk(clk), .rst_n(rst_n), .done(done), .done_bank(done_bank),
        .done_len(done_len), .rd_addr(rd_addr), .s_act(s_act),
        .s_first(s_first), .s_data(s_data), .s_len(s_len)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_len   <= '0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s_act;
            out_sof   <= s_first;
            if (s_act) out_len <= s_len;
            out_re    <= s_data ? rdata[2*DW-1:DW] : '0;
            out_im    <= s_data ? rdata[DW-1:0]    : '0;
        end
    end

    // R4
    sof_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sof);

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> $stable(out_len));
endmodule

// File: tb/zstuff_pingpong_tb.sv
`timescale 1ns/1ps
module zstuff_pingpong_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0;
    logic [2:0]  in_len = '0;
    logic [15:0] in_re = '0, in_im = '0;
    logic        out_valid, out_sof;
    logic [2:0]  out_len;
    logic [15:0] out_re, out_im;

    always #2 clk = ~clk;

    zstuff_pingpong u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_len(in_len), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
        .out_sof(out_sof), .out_len(out_len), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int exp_code [16];
    int exp_seed [16];
    int exp_last [16];
    bit exp_lat  [16];
    bit exp_b2b  [16];
    int wp = 0, rp = 0;
    int last_sof = -4096;
    int prev_out_sof = -100000;
    bit mon_busy = 1'b0;

    function automatic logic [15:0] smp_re(int seed, int i);
        return 16'(seed * 256 + i * 3 + 1);
    endfunction
    function automatic logic [15:0] smp_im(int seed, int i);
        return ~16'(seed + i * 5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor: compares every output frame against the queue
    task automatic check_frame();
        int slot, code, step, sof_c;
        int bad_s, bad_d, bad_l, fp, fa, fe;
        bit ok;
        mon_busy = 1'b1;
        sof_c = cyc;
        if (rp == wp) begin
            check(1'b0, "R2/R10", "unexpected output frame", 1, 0);
            slot = 0; code = 0;
        end else begin
            slot = rp % 16;
            code = exp_code[slot];
        end
        step = 16 >> code;
        if (rp != wp && exp_lat[slot])
            check(sof_c - exp_last[slot] == 4, "R3", "latency edges",
                  sof_c - exp_last[slot] - 1, 3);
        if (rp != wp && exp_b2b[slot])
            check(sof_c - prev_out_sof == 2048, "R8", "back-to-back spacing",
                  sof_c - prev_out_sof, 2048);
        bad_s = 0; bad_d = 0; bad_l = 0; fp = -1; fa = 0; fe = 0;
        for (int p = 0; p < 2048; p++) begin
            logic [31:0] e;
            if (p > 0) @(negedge clk);
            if (!out_valid || out_sof != (p == 0)) bad_s++;
            if (int'(out_len) != code) bad_l++;
            e = (p % step == 0) ? {smp_re(exp_seed[slot], p / step),
                                   smp_im(exp_seed[slot], p / step)} : 32'd0;
            if ({out_re, out_im} !== e) begin
                if (fp < 0) begin fp = p; fa = int'({out_re, out_im}); fe = int'(e); end
                bad_d++;
            end
        end
        check(bad_s == 0, "R4", "valid/sof cycles wrong", bad_s, 0);
        check(bad_l == 0, "R7", "out_len (R6 code)", bad_l, 0);
        ok = (bad_d == 0);
        if (!ok) $display("  first data mismatch at position %0d", fp);
        check(ok, "R5", "stuffed data word", fa, fe);
        prev_out_sof = sof_c;
        rp++;
        mon_busy = 1'b0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (!out_sof) check(1'b0, "R4", "valid without sof", 1, 0);
                else check_frame();
            end
        end
    end

    task automatic send_frame(input int code, input int mode, input int seed,
                              input bit lat, input bit b2b);
        int ce, n, step, slot;
        ce = (code > 4) ? 4 : code;
        n = 128 << ce;
        step = 2048 / n;
        slot = wp % 16;
        exp_code[slot] = ce; exp_seed[slot] = seed;
        exp_lat[slot] = lat; exp_b2b[slot] = b2b;
        exp_last[slot] = 1 << 30;
        wp++;
        while (cyc < last_sof + 2048) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int g;
            g = (i == 0) ? 0 : (mode == 0) ? 0 : (mode == 1) ? step - 1 : (i * 7 + seed) % 4;
            for (int k = 0; k < g; k++) begin
                in_valid = 1'b0; in_sof = 1'b0; in_re = 16'hBEEF; in_im = 16'h1234;
                @(negedge clk);
            end
            in_valid = 1'b1; in_sof = (i == 0); in_len = 3'(code);
            in_re = smp_re(seed, i); in_im = smp_im(seed, i);
            if (i == 0) last_sof = cyc;
            if (i == n - 1) exp_last[slot] = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_loose(input bit with_sof, input int cnt, input int seed);
        for (int i = 0; i < cnt; i++) begin
            in_valid = 1'b1; in_sof = with_sof && (i == 0); in_len = 3'd1;
            in_re = smp_re(seed, i); in_im = smp_im(seed, i);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic wait_drain();
        while (rp != wp || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic count_idle(input int ncyc, input string req);
        int highs = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (out_valid) highs++;
        end
        check(highs == 0, req, "out_valid with no complete frame", highs, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid && !out_sof, "R1", "valid/sof after reset",
              int'({out_valid, out_sof}), 0);
        check(out_re == 0 && out_im == 0 && out_len == 0, "R1", "data after reset",
              int'({out_re, out_im}), 0);
    endtask

    task automatic t_stray();
        send_loose(1'b0, 30, 99);
        count_idle(100, "R2");
    endtask

    task automatic t_restart();
        wait_drain();
        send_loose(1'b1, 20, 77);
        send_frame(3, 0, 8, 1'b1, 1'b0);   // R9: partial discarded
        wait_drain();
    endtask

    task automatic t_extra();
        wait_drain();
        send_frame(0, 0, 11, 1'b1, 1'b0);
        send_loose(1'b0, 40, 55);          // R10: ignored
        wait_drain();
        count_idle(2100, "R10");
    endtask

    task automatic t_b2b();
        wait_drain();
        send_frame(4, 0, 21, 1'b1, 1'b0);
        send_frame(0, 0, 22, 1'b0, 1'b1);  // R8, R7: code differs
        send_frame(2, 0, 23, 1'b0, 1'b1);
        wait_drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stray();
        wait_drain(); send_frame(0, 0, 1, 1'b1, 1'b0);   // R3, R5, R6
        wait_drain(); send_frame(1, 1, 2, 1'b1, 1'b0);   // R5 spaced input
        wait_drain(); send_frame(2, 2, 3, 1'b1, 1'b0);   // R2 scattered input
        t_restart();
        t_extra();
        wait_drain(); send_frame(6, 2, 4, 1'b1, 1'b0);   // R6 clamp
        wait_drain(); send_frame(3, 1, 5, 1'b1, 1'b0);
        t_b2b();
        check(rp == wp, "R8", "frames out vs frames completed", rp, wp);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule